// File: doc/BRIEF.md
# Bus Port Halt Handshake Controller

This controller quiets a single bus port before the surrounding logic removes its power. A one-cycle command starts it. If the port already reports idle, the controller finishes straight away and never raises the halt request. If the port is not idle, the controller raises the halt request and then checks the port's acknowledge input. It checks only on edges where a millisecond tick input is high, and it gives up after a parameterised number of ticks.

When the wait ends, the controller decides the outcome from the port's idle input, not from the acknowledge. It then drops the halt request and emits a one-cycle done pulse with a two-bit result code. Dropping the request does not release the port, which stays halted until it is reset. The controller sits between a power sequencer and the port's halt interface.

Top module: `port_quiesce_ctrl`

## Requirements
- R1: A command that arrives while `port_idle` is high gives `done` high with `result` = 0 on the next cycle, and `halt_req` stays low.
- R2: A command that arrives while `port_idle` is low sets `halt_req` high from the next cycle.
- R3: While `halt_req` is high, `port_halt_ack` is looked at only on clock edges where `tick_ms` is high, so `halt_req` cannot fall on an edge without a tick.
- R4: The wait ends on the first tick edge at which `port_halt_ack` is high.
- R5: If no acknowledge has been seen after `TIMEOUT_TICKS` tick edges (default 100), the wait ends on that tick edge.
- R6: At the edge that ends the wait, `port_idle` decides the outcome: `result` = 1 if it is high and 2 if it is low. This holds whether or not an acknowledge arrived.
- R7: `halt_req` falls in the same cycle that `done` pulses, for both outcomes. `done` lasts exactly one cycle, and `result` never takes the value 3.
- R8: A command that arrives while `halt_req` is high is ignored. It does not restart the timeout and does not produce a second done pulse.
- R9: After reset, `halt_req` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_cmd | input | 1 | One-cycle command to quiesce the port |
| port_idle | input | 1 | Port reports no outstanding traffic |
| port_halt_ack | input | 1 | Port acknowledges the halt request |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| halt_req | output | 1 | Halt request to the port; high while waiting |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | Outcome: 0 already idle, 1 halted, 2 failed |

## Verification
The bench builds the controller with `TIMEOUT_TICKS` = 6. With this value the timeout edge comes within a few dozen cycles, so randomised runs cover all of these cases often:
- an acknowledge just before the limit,
- an acknowledge exactly at the limit,
- an acknowledge that never arrives in time.

A behavioural port model sets its acknowledge latency in ticks from 0 up to past the limit. It can also raise idle late without ever acknowledging, which shows that the outcome is judged from idle alone. Ticks arrive at random spacing, including long stretches with none, so the bench also shows that the acknowledge is only looked at on tick edges.

// File: rtl/port_quiesce_ctrl.sv
module port_quiesce_ctrl #(
  parameter int TIMEOUT_TICKS = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_cmd,
  input  logic       port_idle,
  input  logic       port_halt_ack,
  input  logic       tick_ms,
  output logic       halt_req,
  output logic       done,
  output logic [1:0] result
);
  localparam int CW = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);
  localparam logic [1:0] RES_IDLE   = 2'd0;
  localparam logic [1:0] RES_HALTED = 2'd1;
  localparam logic [1:0] RES_FAILED = 2'd2;

  logic          waiting;
  logic [CW-1:0] tick_cnt;
  logic          wait_end;

  assign halt_req = waiting;
  assign wait_end = waiting && tick_ms && (port_halt_ack || tick_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting  <= 1'b0;
      tick_cnt <= '0;
      done     <= 1'b0;
      result   <= RES_IDLE;
    end else begin
      done <= 1'b0;
      if (!waiting) begin
        if (halt_cmd) begin
          if (port_idle) begin
            done   <= 1'b1;
            result <= RES_IDLE;
          end else begin
            waiting  <= 1'b1;
            tick_cnt <= '0;
          end
        end
      end else if (wait_end) begin
        waiting <= 1'b0;
        done    <= 1'b1;
        result  <= port_idle ? RES_HALTED : RES_FAILED;
      end else if (tick_ms) begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end
endmodule

module port_quiesce_ctrl_chk #(
  parameter int TIMEOUT_TICKS = 100
) (
  input logic       clk,
  input logic       rst_n,
  input logic       halt_cmd,
  input logic       port_idle,
  input logic       port_halt_ack,
  input logic       tick_ms,
  input logic       halt_req,
  input logic       done,
  input logic [1:0] result
);
  localparam int CW = $clog2(TIMEOUT_TICKS + 2);
  logic [CW-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (!halt_req) seen <= '0;
    else if (tick_ms) seen <= seen + 1'b1;
  end

  assert_idle_skip_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_req && halt_cmd && port_idle) |=> (done && result == 2'd0 && !halt_req));
  assert_req_raised_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_req && halt_cmd && !port_idle) |=> halt_req);
  assert_tick_paced_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !tick_ms) |=> halt_req);
  assert_ack_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && tick_ms && port_halt_ack) |=> (done && !halt_req));
  assert_bounded_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> (int'(seen) < TIMEOUT_TICKS));
  assert_idle_judges_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && tick_ms && port_halt_ack) |=> (result == ($past(port_idle) ? 2'd1 : 2'd2)));
  assert_req_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!halt_req && result != 2'd3));
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && halt_cmd && !tick_ms) |=> (halt_req && !done));
endmodule

bind port_quiesce_ctrl port_quiesce_ctrl_chk #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .halt_cmd(halt_cmd), .port_idle(port_idle),
  .port_halt_ack(port_halt_ack), .tick_ms(tick_ms), .halt_req(halt_req),
  .done(done), .result(result)
);

// File: tb/port_quiesce_ctrl_tb.sv
module port_quiesce_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int T = 6;
  localparam int NEVER = 999;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_cmd = 1'b0;
  logic tick_ms = 1'b0;
  logic port_idle, port_halt_ack;
  logic halt_req, done;
  logic [1:0] result;

  int checks = 0;
  int failures = 0;
  logic gen_ticks = 1'b1;

  int pre_idle_v = 0;
  int lat_v = NEVER;
  int follows_v = 1;
  int late_at_v = NEVER;
  int mticks = 0;
  int nticks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_quiesce_ctrl #(.TIMEOUT_TICKS(T)) u_dut (
    .clk(clk), .rst_n(rst_n), .halt_cmd(halt_cmd), .port_idle(port_idle),
    .port_halt_ack(port_halt_ack), .tick_ms(tick_ms), .halt_req(halt_req),
    .done(done), .result(result)
  );

  // behavioural port: acknowledge after lat_v ticks of request
  assign port_halt_ack = halt_req && (mticks >= lat_v);
  assign port_idle = (pre_idle_v != 0) || (port_halt_ack && follows_v != 0) ||
                     (halt_req && mticks >= late_at_v);

  always @(posedge clk) begin
    if (!halt_req) mticks <= 0;
    else if (tick_ms) mticks <= mticks + 1;
    if (halt_cmd && !halt_req) nticks <= 0;
    else if (halt_req && tick_ms) nticks <= nticks + 1;
  end

  always @(negedge clk) tick_ms <= gen_ticks && ($urandom % 3 == 0);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_ticks(input int lat);
    return (lat + 1 <= T) ? lat + 1 : T;
  endfunction

  function automatic int exp_result(input int lat, input int follows, input int late_at);
    int j;
    logic ack, idle;
    j = exp_ticks(lat);
    ack = (lat + 1 <= T);
    idle = (ack && follows != 0) || (j - 1 >= late_at);
    return idle ? 1 : 2;
  endfunction

  task automatic run(input int pre, input int lat, input int follows,
                     input int late_at, input bit extra_cmd);
    int guard;
    @(negedge clk);
    pre_idle_v = pre; lat_v = lat; follows_v = follows; late_at_v = late_at;
    halt_cmd = 1'b1;
    @(negedge clk);
    halt_cmd = 1'b0;
    if (pre != 0) begin
      check("R1 done", done, 1);
      check("R1 result", result, 0);
      check("R1 halt_req", halt_req, 0);
    end else begin
      check("R2 halt_req", halt_req, 1);
      if (extra_cmd) begin
        halt_cmd = 1'b1;
        @(negedge clk);
        halt_cmd = 1'b0;
      end
      guard = 0;
      while (!done && guard < 2000) begin
        @(negedge clk);
        guard++;
      end
      check("R4/R5 finished", done, 1);
      check(lat + 1 <= T ? "R4 tick count" : "R5 tick count", nticks, exp_ticks(lat));
      check("R6 result", result, exp_result(lat, follows, late_at));
      check("R7 halt_req dropped", halt_req, 0);
    end
    pre_idle_v = 0;
    @(negedge clk);
    check("R7 single pulse", done, 0);
    if (extra_cmd) begin
      repeat (4) begin
        @(negedge clk);
        check("R8 no second done", done, 0);
        check("R8 no new request", halt_req, 0);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R9 halt_req", halt_req, 0);
    check("R9 done", done, 0);
    rst_n = 1'b1;

    run(1, NEVER, 1, NEVER, 1'b0);          // already idle
    run(0, 0, 1, NEVER, 1'b0);              // ack at once
    run(0, T - 1, 1, NEVER, 1'b0);          // ack on the last tick
    run(0, T, 1, NEVER, 1'b0);              // ack just too late
    run(0, NEVER, 1, NEVER, 1'b0);          // never acked, never idle
    run(0, 2, 0, NEVER, 1'b0);              // ack but idle low
    run(0, NEVER, 1, 2, 1'b0);              // idle without ack
    run(0, 3, 1, NEVER, 1'b1);              // command while busy

    // R3: with no ticks the request must hold even though ack is high
    @(negedge clk);
    gen_ticks = 1'b0;
    @(negedge clk);
    lat_v = 0; follows_v = 1; late_at_v = NEVER;
    halt_cmd = 1'b1;
    @(negedge clk);
    halt_cmd = 1'b0;
    repeat (20) @(negedge clk);
    check("R3 held without tick", halt_req, 1);
    check("R3 no done without tick", done, 0);
    gen_ticks = 1'b1;
    while (!done) @(negedge clk);
    check("R3 result after tick", result, 1);
    @(negedge clk);

    for (int i = 0; i < 60; i++) begin
      int pre, lat, fol, late;
      pre  = ($urandom % 5 == 0) ? 1 : 0;
      lat  = $urandom % (T + 3);
      fol  = ($urandom % 4 != 0) ? 1 : 0;
      late = ($urandom % 3 == 0) ? int'($urandom % T) : NEVER;
      run(pre, lat, fol, late, ($urandom % 6 == 0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule